// File: doc/BRIEF.md
# Width-Switchable Byte-Lane Static Memory Core

This block is a clocked static memory that software or a neighbouring block can view either as an array of 16-bit words or as an array of 8-bit bytes. A mode input selects the view on every access, so the choice can change from one cycle to the next. In the byte view, one extra low-order address input is added below the word address. That input picks which half of the underlying word is accessed, so the word view and the byte view read and write the same storage.

An access is accepted only when both chip enables are active and at least one byte-lane enable is active. The two chip enables have opposite polarity. A write happens when the write strobe is low. A read happens when the write strobe is high and the output enable is low. Read data is registered. Instead of tri-state drivers, each 8-bit output lane carries its own valid flag. A lane that is not valid reads as zero.

Top module: `bsram_core`

## Requirements
- R1: The core is selected only while `cs1_n` is 0 and `cs2` is 1. While it is not selected, no write changes memory, and one cycle later both bits of `rvalid` are 0.
- R2: When `hi_en_n` and `lo_en_n` are both 1, the core is treated as not selected: nothing is written, and one cycle later `rvalid` is 2'b00.
- R3: When `word_mode` is 1, `addr` selects one 16-bit word and `byte_sel` has no effect on which location is accessed.
- R4: When `word_mode` is 0, the byte address is {`addr`,`byte_sel`}. A `byte_sel` of 0 addresses bits 7:0 of word `addr`, and a `byte_sel` of 1 addresses bits 15:8 of that word. The data for the byte travels on `wdata[7:0]` and `rdata[7:0]`.
- R5: While selected, `wr_n` = 0 writes the addressed location whatever the value of `rd_n`, and one cycle later `rvalid` is 2'b00.
- R6: While selected, `wr_n` = 1 together with `rd_n` = 0 performs a read. If `rd_n` is 1, no read occurs and one cycle later `rvalid` is 2'b00.
- R7: In word mode, `lo_en_n` = 0 enables lane 0 (bits 7:0) and `hi_en_n` = 0 enables lane 1 (bits 15:8), for both writes and reads. A disabled lane is neither written nor flagged valid, so a word read returns `rvalid` = {~`hi_en_n`,~`lo_en_n`}.
- R8: In byte mode, a read returns `rvalid` = 2'b01 and `rdata[15:8]` = 0. A byte write changes only the one addressed byte.
- R9: Read data and valid flags appear on the clock edge after the one that samples the access. Any lane whose valid bit is 0 outputs 0.
- R10: An active-low asynchronous reset `rst_n` clears `rvalid` and the output data. Reset does not alter the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all accesses are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| word_mode | input | 1 | 1 = 16-bit word view, 0 = 8-bit byte view |
| addr | input | AW | Word address |
| byte_sel | input | 1 | Low-order byte address bit, used only in byte view |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Output enable, active low |
| hi_en_n | input | 1 | Upper lane enable (bits 15:8), active low |
| lo_en_n | input | 1 | Lower lane enable (bits 7:0), active low |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data; invalid lanes read 0 |
| rvalid | output | 2 | Per-lane valid flags; bit 0 is the low lane, bit 1 the high lane |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge. They also assume that the inputs stay idle, with the chip not selected, while reset is held, so that no check begins on an access that reset has cut short. The stimulus drives every input at the falling edge, which keeps setup clean. It holds `cs1_n` high throughout reset and fills the whole array with word writes before any read, so the assertions and the reference model never depend on contents that were never initialized. After that, the stimulus mixes directed corner cases with a long run of random accesses that cover both views and every enable combination.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LW    = 8;
  localparam int LANES = 2;
  localparam int DW    = LW * LANES;

  // Core is addressed only with both chip enables active and any lane on.
  function automatic logic chip_on(input logic c1n, input logic c2,
                                   input logic hin, input logic lon);
    return ~c1n & c2 & ~(hin & lon);
  endfunction

  // Lanes enabled for a word-view access.
  function automatic logic [LANES-1:0] word_lanes(input logic hin, input logic lon);
    return {~hin, ~lon};
  endfunction

  // Single lane targeted by a byte-view access.
  function automatic logic [LANES-1:0] byte_lane(input logic bsel);
    return bsel ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
(
  input  logic                    word_mode,
  input  logic                    byte_sel,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    wr_n,
  input  logic                    rd_n,
  input  logic                    hi_en_n,
  input  logic                    lo_en_n,
  input  logic [DW-1:0]           wdata,
  output logic                    sel,
  output logic [LANES-1:0]        wr_lane,
  output logic [LANES-1:0]        rd_lane,
  output logic [LANES-1:0][LW-1:0] lane_wd,
  output logic [LANES-1:0]        nxt_valid,
  output logic                    nxt_hi_route
);
  logic [LANES-1:0] tgt;

  always_comb begin
    sel = chip_on(cs1_n, cs2, hi_en_n, lo_en_n);
    tgt = word_mode ? word_lanes(hi_en_n, lo_en_n) : byte_lane(byte_sel);
    wr_lane = (sel && !wr_n) ? tgt : '0;
    rd_lane = (sel && wr_n && !rd_n) ? tgt : '0;
    // Outputs: word view keeps lanes in place, byte view folds onto lane 0.
    if (word_mode) nxt_valid = rd_lane;
    else           nxt_valid = (rd_lane != '0) ? 2'b01 : 2'b00;
    nxt_hi_route = !word_mode && byte_sel;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_wd
    assign lane_wd[k] = word_mode ? wdata[k*LW +: LW] : wdata[LW-1:0];
  end
endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
  parameter int AW = 6,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] wd,
  output logic [LW-1:0] rq
);
  localparam int DEPTH = 1 << AW;
  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rq <= mem[addr];
  end
endmodule

// File: rtl/bsram_outreg.sv
module bsram_outreg
  import bsram_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         nxt_valid,
  input  logic                     nxt_hi_route,
  input  logic [LANES-1:0][LW-1:0] q,
  output logic [DW-1:0]            rdata,
  output logic [LANES-1:0]         rvalid
);
  logic hi_route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid   <= '0;
      hi_route <= 1'b0;
    end else begin
      rvalid   <= nxt_valid;
      hi_route <= nxt_hi_route;
    end
  end

  always_comb begin
    rdata[LW-1:0]  = rvalid[0] ? (hi_route ? q[1] : q[0]) : '0;
    rdata[DW-1:LW] = rvalid[1] ? q[1] : '0;
  end
endmodule

// File: rtl/bsram_core.sv
module bsram_core
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_mode,
  input  logic [AW-1:0] addr,
  input  logic          byte_sel,
  input  logic          cs1_n,
  input  logic          cs2,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          hi_en_n,
  input  logic          lo_en_n,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic [1:0]    rvalid
);
  logic                     sel_w;
  logic [LANES-1:0]         wr_lane;
  logic [LANES-1:0]         rd_lane;
  logic [LANES-1:0][LW-1:0] lane_wd;
  logic [LANES-1:0][LW-1:0] lane_q;
  logic [LANES-1:0]         nxt_valid;
  logic                     nxt_hi_route;

  bsram_decode u_dec (
    .word_mode(word_mode), .byte_sel(byte_sel), .cs1_n(cs1_n), .cs2(cs2),
    .wr_n(wr_n), .rd_n(rd_n), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
    .wdata(wdata), .sel(sel_w), .wr_lane(wr_lane), .rd_lane(rd_lane),
    .lane_wd(lane_wd), .nxt_valid(nxt_valid), .nxt_hi_route(nxt_hi_route)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bsram_lane #(.AW(AW), .LW(LW)) u_lane (
      .clk(clk), .we(wr_lane[k]), .re(rd_lane[k]), .addr(addr),
      .wd(lane_wd[k]), .rq(lane_q[k])
    );
  end

  bsram_outreg u_out (
    .clk(clk), .rst_n(rst_n), .nxt_valid(nxt_valid),
    .nxt_hi_route(nxt_hi_route), .q(lane_q), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/bsram_core_chk.sv
module bsram_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_mode,
  input logic        cs1_n,
  input logic        cs2,
  input logic        wr_n,
  input logic        rd_n,
  input logic        hi_en_n,
  input logic        lo_en_n,
  input logic        sel_w,
  input logic [1:0]  wr_lane,
  input logic [1:0]  rd_lane,
  input logic [15:0] rdata,
  input logic [1:0]  rvalid
);
  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs1_n || !cs2) |=> (rvalid == 2'b00));

  p_no_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en_n && lo_en_n) |=> (rvalid == 2'b00));

  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> (rvalid == 2'b00));

  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> (rvalid == 2'b00));

  p_word_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mode && sel_w && wr_n && !rd_n) |=> (rvalid == $past({~hi_en_n, ~lo_en_n})));

  p_byte_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> $onehot0(wr_lane | rd_lane));

  p_byte_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |=> (!rvalid[1] && rdata[15:8] == 8'h00));

  p_zero_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid[0] |-> (rdata[7:0] == 8'h00));

  p_zero_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid[1] |-> (rdata[15:8] == 8'h00));
endmodule

bind bsram_core bsram_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .cs1_n(cs1_n), .cs2(cs2),
  .wr_n(wr_n), .rd_n(rd_n), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
  .sel_w(sel_w), .wr_lane(wr_lane), .rd_lane(rd_lane),
  .rdata(rdata), .rvalid(rvalid)
);

// File: tb/tb_bsram_core.sv
module tb_bsram_core;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          word_mode, byte_sel, cs1_n, cs2, wr_n, rd_n, hi_en_n, lo_en_n;
  logic [AW-1:0] addr;
  logic [15:0]   wdata;
  logic [15:0]   rdata;
  logic [1:0]    rvalid;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  byte unsigned bmem [2*NW];

  always #5 clk = ~clk;

  bsram_core #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .addr(addr),
    .byte_sel(byte_sel), .cs1_n(cs1_n), .cs2(cs2), .wr_n(wr_n), .rd_n(rd_n),
    .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .wdata(wdata), .rdata(rdata),
    .rvalid(rvalid)
  );

  task automatic check(input string tag, input logic [15:0] ed, input logic [1:0] ev);
    total++;
    if (rdata !== ed || rvalid !== ev) begin
      bad++;
      $display("FAIL %s: rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
               tag, rdata, rvalid, ed, ev);
    end
  endtask

  // Drive one access at a falling edge, update the model, compare after the next rising edge.
  task automatic step(input logic wm, input int a, input logic b, input logic c1n,
                      input logic c2, input logic wn, input logic rn, input logic hn,
                      input logic ln, input logic [15:0] d, input string tag);
    logic [15:0] ed = 16'h0;
    logic [1:0]  ev = 2'b00;
    bit          on;
    int          base = 2 * a;
    word_mode = wm; addr = AW'(a); byte_sel = b; cs1_n = c1n; cs2 = c2;
    wr_n = wn; rd_n = rn; hi_en_n = hn; lo_en_n = ln; wdata = d;
    on = (c1n == 0) && (c2 == 1) && !(hn && ln);
    if (on && !wn) begin
      if (wm) begin
        if (!ln) bmem[base]     = d[7:0];
        if (!hn) bmem[base + 1] = d[15:8];
      end else begin
        bmem[base + int'(b)] = d[7:0];
      end
    end else if (on && !rn) begin
      if (wm) begin
        if (!ln) begin ev[0] = 1'b1; ed[7:0]  = bmem[base]; end
        if (!hn) begin ev[1] = 1'b1; ed[15:8] = bmem[base + 1]; end
      end else begin
        ev = 2'b01;
        ed[7:0] = bmem[base + int'(b)];
      end
    end
    @(negedge clk);
    check(tag, ed, ev);
  endtask

  task automatic idle();
    word_mode = 1'b1; addr = '0; byte_sel = 1'b0; cs1_n = 1'b1; cs2 = 1'b0;
    wr_n = 1'b1; rd_n = 1'b1; hi_en_n = 1'b1; lo_en_n = 1'b1; wdata = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset state", 16'h0, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    // Fill whole array in word view (R5: write with output enable low gives no output)
    for (int i = 0; i < NW; i++)
      step(1, i, 0, 0, 1, 0, 0, 0, 0, 16'(i * 16'h0403 + 16'h1A5C), "R5 word fill");

    // R3: byte_sel ignored in word view
    step(1, 5, 0, 0, 1, 1, 0, 0, 0, 16'h0, "R3 word read b=0");
    step(1, 5, 1, 0, 1, 1, 0, 0, 0, 16'h0, "R3 word read b=1");
    step(1, 9, 1, 0, 1, 0, 1, 0, 0, 16'hBEEF, "R3 word write b=1");
    step(1, 9, 0, 0, 1, 1, 0, 0, 0, 16'h0, "R3 readback");

    // R7: lane gating
    step(1, 12, 0, 0, 1, 0, 1, 1, 0, 16'hAA11, "R7 low-lane write");
    step(1, 12, 0, 0, 1, 0, 1, 0, 1, 16'h22BB, "R7 high-lane write");
    step(1, 12, 0, 0, 1, 1, 0, 0, 0, 16'h0, "R7 full read");
    step(1, 12, 0, 0, 1, 1, 0, 1, 0, 16'h0, "R7 low-lane read");
    step(1, 12, 0, 0, 1, 1, 0, 0, 1, 16'h0, "R7 high-lane read");

    // R4/R8: byte view shares storage with word view
    step(0, 20, 0, 0, 1, 0, 0, 1, 0, 16'hFF5A, "R4 byte write lo");
    step(0, 20, 1, 0, 1, 0, 0, 1, 0, 16'hFFC3, "R4 byte write hi");
    step(1, 20, 0, 0, 1, 1, 0, 0, 0, 16'h0, "R4 word view of bytes");
    step(0, 21, 1, 0, 1, 1, 0, 0, 1, 16'h0, "R8 byte read hi half");
    step(0, 21, 0, 0, 1, 1, 0, 1, 0, 16'h0, "R8 byte read lo half");

    // R1/R2: not selected -> no write, no output
    step(1, 30, 0, 1, 1, 0, 0, 0, 0, 16'h1111, "R1 cs1_n high write");
    step(1, 30, 0, 0, 0, 0, 0, 0, 0, 16'h2222, "R1 cs2 low write");
    step(1, 30, 0, 1, 1, 1, 0, 0, 0, 16'h0, "R1 read deselected");
    step(1, 30, 0, 0, 1, 0, 0, 1, 1, 16'h3333, "R2 no lanes write");
    step(0, 30, 1, 0, 1, 1, 0, 1, 1, 16'h0, "R2 no lanes byte read");
    step(1, 30, 0, 0, 1, 1, 0, 0, 0, 16'h0, "R1 R2 contents kept");

    // R6: output enable off
    step(1, 31, 0, 0, 1, 1, 1, 0, 0, 16'h0, "R6 rd_n high");
    // R9: invalid after a valid read returns zeros
    step(1, 31, 0, 0, 1, 1, 0, 0, 0, 16'h0, "R9 valid read");
    step(1, 31, 0, 1, 0, 1, 1, 1, 1, 16'h0, "R9 idle zero");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] r = 5'($urandom);
      step(logic'($urandom), int'($urandom % NW), logic'($urandom),
           (r[1:0] == 0), (r[3:2] != 0), logic'($urandom), logic'($urandom),
           logic'($urandom), logic'($urandom), 16'($urandom), "R9 random mix");
    end

    // R10: reset keeps contents
    step(1, 40, 0, 0, 1, 0, 0, 0, 0, 16'h5AA5, "R10 pre-reset write");
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears outputs", 16'h0, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 40, 0, 0, 1, 1, 0, 0, 0, 16'h0, "R10 contents survive reset");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule